// File: doc/BRIEF.md
# Read-Calibration Pattern Source for a DRAM Device Model

This block is the device-side half of read-timing calibration in a high-speed DRAM model. A memory controller sends commands on a one-command-per-cycle port. The block holds two mode registers. The data-latency register sets how many cycles pass between a READ and its first data beat. The calibration register turns training on and off and picks the pattern. While training is off, every READ answers with a four-beat burst of all-zero data. This stand-in replaces the array contents, which this block does not model. While training is on, every READ to bank 0 answers with a fixed toggling pattern on the DQ lanes. The pattern is either the same on every lane, or opposite on even and odd lanes. The controller sweeps its capture point against this known waveform.

While training is on, only bank-0 READs are legal, plus one mode-register write that switches training off. Any other command raises a one-cycle error pulse and is otherwise ignored. The exit command is also rejected while a training burst is pending or on the bus. Reads to bank 0 may be sent every four cycles, so the pattern streams without gaps.

Top module: `rdtrain_gen`

## Requirements
- R1: After a synchronous active-low reset, dq_valid and err_flag are 0, training is off and the data latency is DEF_LAT (3 by default).
- R2: A mode-register write (cmd_op=3) with cmd_ba=4'b0000 loads the latency L from cmd_addr[LAT_W-1:0]. A READ sampled at clock edge k drives its first beat from edge k+L, and its four beats stay on consecutive cycles. A latency of 0 behaves as 1.
- R3: With training off, a READ (cmd_op=1) to any bank gives four beats with dq_valid high and dq_out all zeros.
- R4: A mode-register write with cmd_ba=4'b0010 and cmd_addr[2]=1 turns training on. The pattern code is cmd_addr[1:0]. Code 00 drives beats 0,1,0,1 on every lane. Code 01 drives 0,1,0,1 on even lanes and 1,0,1,0 on odd lanes.
- R5: A write that enables training with a reserved code (cmd_addr[1]=1) raises err_flag and leaves the mode unchanged.
- R6: While training is on, a WRITE (cmd_op=2) raises err_flag and produces no data.
- R7: While training is on, a READ with cmd_ba other than 0 raises err_flag and produces no burst. For a bank-0 READ, cmd_addr has no effect on the data.
- R8: Training READs sent every four cycles give an unbroken run of dq_valid, and the pattern repeats.
- R9: Any mode-register write with cmd_ba[3:2] not 00 raises err_flag and changes no register, in either mode.
- R10: While training is on, a mode-register write with cmd_ba=4'b0010 and cmd_addr[2]=0 turns training off. It is accepted only if no training READ is pending and dq_valid is low in the cycle the command is presented. Otherwise it raises err_flag and training stays on.
- R11: While training is on, every other mode-register write raises err_flag and is ignored. This covers writes to the latency register, writes to the calibration register with cmd_addr[2]=1, and writes with cmd_ba[1:0] of 01 or 11.
- R12: Reset applied while training is on returns the block to normal mode with the default latency.
- R13: err_flag is high for exactly the one cycle after an offending command is sampled. NOP (cmd_op=0), and WRITE while training is off, never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_op | input | 2 | Command: 0 NOP, 1 READ, 2 WRITE, 3 mode-register write |
| cmd_ba | input | 4 | Bank address; for mode-register writes, [1:0] selects the register |
| cmd_addr | input | ADDR_W | Address; carries the register value for mode-register writes |
| dq_out | output | DQ_W | Data lanes |
| dq_valid | output | 1 | High while a burst beat is on dq_out |
| err_flag | output | 1 | One-cycle pulse for an illegal command |

## Verification
Two functions can meet in one cycle: a burst beat leaving on the bus, and a new command being judged against that burst's state. The bench provokes the sharpest case of this. It presents the exit command on the exact cycle the final training beat is visible, and expects err_flag with training still on. It then presents the same command one cycle later and expects it to be accepted, which a following READ confirms by returning zeros. The second pairing is a READ arriving while the previous burst is still streaming. The scoreboard judges it by requiring every expected beat on its computed cycle, with no gap between bursts.

// File: rtl/rdtrain_pkg.sv
// Package: shared command codes, the pending-read token and the lane pattern rule.
// Assumes one command per clock; code values are fixed by the port definition.
package rdtrain_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_MRS   = 2'd3
    } cmd_t;

    // One accepted READ travelling through the latency line.
    typedef struct packed {
        logic live;   // a read occupies this stage
        logic train;  // issued while training was on
        logic alt;    // odd lanes carry the inverted pattern
    } token_t;

    // Bit on one lane for one beat: beats toggle 0,1,0,1; odd lanes may invert.
    function automatic logic lane_bit(input logic train, input logic alt,
                                      input logic [1:0] beat, input logic odd_lane);
        return train & (beat[0] ^ (alt & odd_lane));
    endfunction

endpackage

// File: rtl/rdtrain_cmdchk.sv
// Module: rdtrain_cmdchk
// Classifies the command presented this cycle as an accepted read, a register
// write, or an illegal command, given the current mode and burst activity.
// Purely combinational; assumes the caller registers the illegal indication.
module rdtrain_cmdchk
    import rdtrain_pkg::*;
(
    input  cmd_t       op,
    input  logic [3:0] ba,
    input  logic       mr_en,      // calibration enable field of the value
    input  logic       mr_rsvd,    // upper bit of the pattern code
    input  logic       train_en,
    input  logic       busy,
    output logic       acc_read,
    output logic       mr0_wr,
    output logic       mr2_wr,
    output logic       illegal
);

    logic ba_hi_bad;
    logic sel_lat;
    logic sel_cal;

    assign ba_hi_bad = |ba[3:2];
    assign sel_lat   = (ba[1:0] == 2'b00);
    assign sel_cal   = (ba[1:0] == 2'b10);

    // Decide legality and the effect of the command under the current mode.
    always_comb begin
        acc_read = 1'b0;
        mr0_wr   = 1'b0;
        mr2_wr   = 1'b0;
        illegal  = 1'b0;
        unique case (op)
            CMD_NOP: ;
            CMD_READ: begin
                if (!train_en || ba == 4'd0) acc_read = 1'b1;
                else                         illegal  = 1'b1;
            end
            CMD_WRITE: begin
                illegal = train_en;
            end
            CMD_MRS: begin
                if (ba_hi_bad) begin
                    illegal = 1'b1;
                end else if (train_en) begin
                    if (sel_cal && !mr_en && !busy) mr2_wr  = 1'b1;
                    else                            illegal = 1'b1;
                end else if (sel_lat) begin
                    mr0_wr = 1'b1;
                end else if (sel_cal) begin
                    if (mr_en && mr_rsvd) illegal = 1'b1;
                    else                  mr2_wr  = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rdtrain_modereg.sv
// Module: rdtrain_modereg
// Holds the data-latency field and the calibration enable and pattern choice.
// Assumes the write strobes are already qualified as legal by the checker.
module rdtrain_modereg #(
    parameter int LAT_W   = 4,
    parameter int DEF_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr0_wr,
    input  logic             mr2_wr,
    input  logic [LAT_W-1:0] lat_val,
    input  logic             en_val,
    input  logic             alt_val,
    output logic [LAT_W-1:0] lat,
    output logic             train_en,
    output logic             alt_sel
);

    // Latency register: reset to the default, loaded by a latency write.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat <= LAT_W'(DEF_LAT);
        else if (mr0_wr) lat <= lat_val;
    end

    // Calibration register: enable and lane-inversion choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_en <= 1'b0;
            alt_sel  <= 1'b0;
        end else if (mr2_wr) begin
            train_en <= en_val;
            alt_sel  <= en_val & alt_val;
        end
    end

endmodule

// File: rtl/rdtrain_burst.sv
// Module: rdtrain_burst
// Delays each accepted read by the programmed latency, then emits four beats.
// Assumes reads are spaced at least four cycles apart and the latency is not
// changed while reads are in flight; a new start restarts the beat count.
module rdtrain_burst
    import rdtrain_pkg::*;
#(
    parameter int DQ_W  = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  token_t           issue,
    input  logic [LAT_W-1:0] lat,
    output logic             busy,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_valid
);

    localparam int DEPTH = (1 << LAT_W) - 1;

    token_t             line_q [DEPTH];
    logic [DEPTH-1:0]   in_window;
    logic [LAT_W-1:0]   lat_eff;
    token_t             pick;
    logic               active;
    logic [1:0]         beat;
    logic               cur_train;
    logic               cur_alt;

    assign lat_eff = (lat == '0) ? LAT_W'(1) : lat;
    assign pick    = line_q[lat_eff - 1'b1];

    // Latency line entry stage: capture the token of this cycle's command.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q[0] <= '0;
        else        line_q[0] <= issue;
    end

    genvar gi;
    generate
        for (gi = 1; gi < DEPTH; gi++) begin : g_stage
            // Latency line stage: shift the token one cycle further.
            always_ff @(posedge clk) begin
                if (!rst_n) line_q[gi] <= '0;
                else        line_q[gi] <= line_q[gi-1];
            end
        end
        for (gi = 0; gi < DEPTH; gi++) begin : g_window
            // A stage counts as pending only before the tap is reached.
            assign in_window[gi] = line_q[gi].live && (int'(lat_eff) > gi);
        end
    endgenerate

    // Burst sequencer: start on a tapped token, count four beats, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            beat      <= 2'd0;
            cur_train <= 1'b0;
            cur_alt   <= 1'b0;
        end else if (pick.live) begin
            active    <= 1'b1;
            beat      <= 2'd0;
            cur_train <= pick.train;
            cur_alt   <= pick.alt;
        end else if (active) begin
            if (beat == 2'd3) active <= 1'b0;
            else              beat   <= beat + 2'd1;
        end
    end

    generate
        for (gi = 0; gi < DQ_W; gi++) begin : g_lane
            // Lane driver: pattern bit for this lane, zero when idle.
            assign dq_out[gi] = active &
                lane_bit(cur_train, cur_alt, beat, 1'((gi % 2)));
        end
    endgenerate

    assign dq_valid = active;
    assign busy     = active | (|in_window);

endmodule

// File: rtl/rdtrain_gen.sv
// Module: rdtrain_gen (top)
// Device-side read-calibration pattern source: decodes commands, holds the
// two mode registers, and returns either zero data or the training pattern.
// Assumes one command per clock and synchronous active-low reset.
module rdtrain_gen
    import rdtrain_pkg::*;
#(
    parameter int DQ_W    = 8,
    parameter int ADDR_W  = 20,
    parameter int LAT_W   = 4,
    parameter int DEF_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_ba,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_valid,
    output logic              err_flag
);

    logic             acc_read;
    logic             mr0_wr;
    logic             mr2_wr;
    logic             illegal;
    logic             busy;
    logic             train_en;
    logic             alt_sel;
    logic [LAT_W-1:0] lat;
    token_t           issue;
    logic             addr_unused;

    assign addr_unused = ^cmd_addr;

    rdtrain_cmdchk u_chk_cmd (
        .op       (cmd_t'(cmd_op)),
        .ba       (cmd_ba),
        .mr_en    (cmd_addr[2]),
        .mr_rsvd  (cmd_addr[1]),
        .train_en (train_en),
        .busy     (busy),
        .acc_read (acc_read),
        .mr0_wr   (mr0_wr),
        .mr2_wr   (mr2_wr),
        .illegal  (illegal)
    );

    rdtrain_modereg #(.LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr0_wr   (mr0_wr),
        .mr2_wr   (mr2_wr),
        .lat_val  (cmd_addr[LAT_W-1:0]),
        .en_val   (cmd_addr[2]),
        .alt_val  (cmd_addr[0]),
        .lat      (lat),
        .train_en (train_en),
        .alt_sel  (alt_sel)
    );

    assign issue = '{live: acc_read, train: train_en, alt: alt_sel};

    rdtrain_burst #(.DQ_W(DQ_W), .LAT_W(LAT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .lat      (lat),
        .busy     (busy),
        .dq_out   (dq_out),
        .dq_valid (dq_valid)
    );

    // Error pulse: one cycle after an illegal command is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= illegal;
    end

endmodule

// File: rtl/rdtrain_gen_chk.sv
// Module: rdtrain_gen_chk
// Property checker for rdtrain_gen, attached by bind; observes ports and the
// training-enable state that the mode register drives.
module rdtrain_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_op,
    input logic [3:0] cmd_ba,
    input logic       addr_en,
    input logic       train_en,
    input logic       dq_valid,
    input logic       err_flag
);

    // R6: a write during training is flagged.
    a_r6_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && cmd_op == 2'd2) |=> err_flag);

    // R7: a training read to a non-zero bank is flagged.
    a_r7_bank_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && cmd_op == 2'd1 && cmd_ba != 4'd0) |=> err_flag);

    // R9: high bank bits on a register write are flagged.
    a_r9_ba_high_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 2'd3 && cmd_ba[3:2] != 2'b00) |=> err_flag);

    // R10: exit presented while a beat is on the bus is refused.
    a_r10_exit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && dq_valid && cmd_op == 2'd3 && cmd_ba == 4'b0010 && !addr_en)
        |=> (err_flag && train_en));

    // R13: an error pulse always follows a non-NOP command.
    a_r13_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $past(cmd_op) != 2'd0);

    // R12: reset clears training and the data strobe.
    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!train_en && !dq_valid && !err_flag));

endmodule

bind rdtrain_gen rdtrain_gen_chk u_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_op   (cmd_op),
    .cmd_ba   (cmd_ba),
    .addr_en  (cmd_addr[2]),
    .train_en (train_en),
    .dq_valid (dq_valid),
    .err_flag (err_flag)
);

// File: tb/rdtrain_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts beats and error pulses from the
// requirements; a monitor compares dq at each falling edge.
module rdtrain_gen_tb;

    localparam int DQ_W = 8;
    localparam int AW   = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cmd_op = 2'd0;
    logic [3:0]      cmd_ba = 4'd0;
    logic [AW-1:0]   cmd_addr = '0;
    logic [DQ_W-1:0] dq_out;
    logic            dq_valid;
    logic            err_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_issue = 0;
    bit finished = 0;

    bit       m_train = 0;
    bit       m_alt = 0;
    int       m_lat = 3;

    int              q_cyc[$];
    logic [DQ_W-1:0] q_dat[$];
    string           q_tag[$];

    rdtrain_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .dq_out(dq_out), .dq_valid(dq_valid),
        .err_flag(err_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DQ_W-1:0] exp_word(bit tr, bit al, int b);
        logic [DQ_W-1:0] w;
        for (int i = 0; i < DQ_W; i++)
            w[i] = tr & ((b % 2 == 1) ^ (al & (i % 2 == 1)));
        return w;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one command at a falling edge, predict effects, check err one cycle on.
    task automatic send(logic [1:0] op, logic [3:0] ba, logic [AW-1:0] addr,
                        bit exp_err, string tag);
        int l;
        cmd_op = op; cmd_ba = ba; cmd_addr = addr;
        last_issue = cyc;
        if (!exp_err && op == 2'd1) begin
            l = (m_lat == 0) ? 1 : m_lat;
            for (int b = 0; b < 4; b++) begin
                q_cyc.push_back(cyc + 1 + l + b);
                q_dat.push_back(exp_word(m_train, m_alt, b));
                q_tag.push_back(tag);
            end
        end
        if (!exp_err && op == 2'd3 && ba == 4'b0000) m_lat = int'(addr[3:0]);
        if (!exp_err && op == 2'd3 && ba == 4'b0010) begin
            m_train = addr[2];
            m_alt   = addr[2] & addr[0];
        end
        @(posedge clk);
        @(negedge clk);
        cmd_op = 2'd0; cmd_ba = 4'd0; cmd_addr = '0;
        check(err_flag == exp_err, tag, "err_flag", int'(err_flag), int'(exp_err));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while (q_cyc.size() != 0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        idle(2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pop and compare each beat at its predicted cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dq_valid) begin
                if (q_cyc.size() == 0) begin
                    check(0, "R13", "unexpected dq_valid", 1, 0);
                end else begin
                    check(q_cyc[0] == cyc, q_tag[0], "beat cycle", cyc, q_cyc[0]);
                    check(dq_out == q_dat[0], q_tag[0], "dq_out", int'(dq_out),
                          int'(q_dat[0]));
                    void'(q_cyc.pop_front()); void'(q_dat.pop_front());
                    void'(q_tag.pop_front());
                end
            end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
                check(0, q_tag[0], "missing beat", 0, 1);
                void'(q_cyc.pop_front()); void'(q_dat.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(dq_valid == 0, "R1", "dq_valid after reset", int'(dq_valid), 0);
        check(err_flag == 0, "R1", "err_flag after reset", int'(err_flag), 0);
        // R1 default latency, R3 zero data in normal mode, any bank
        send(2'd1, 4'd0, 20'h0, 0, "R1");
        drain();
        send(2'd1, 4'd5, 20'h1234, 0, "R3");
        // R13: normal write is legal and silent
        send(2'd2, 4'd1, 20'h0, 0, "R13");
        drain();
        // R2: latency 5, then latency 0 acting as 1, then 2
        send(2'd3, 4'b0000, 20'h5, 0, "R2");
        send(2'd1, 4'd0, 20'h0, 0, "R2");
        drain();
        send(2'd3, 4'b0000, 20'h0, 0, "R2");
        send(2'd1, 4'd0, 20'h0, 0, "R2");
        drain();
        send(2'd3, 4'b0000, 20'h2, 0, "R2");
        // R5: reserved pattern code refused, read stays zero
        send(2'd3, 4'b0010, 20'h6, 1, "R5");
        send(2'd1, 4'd0, 20'h0, 0, "R5");
        drain();
        // R9: high bank bits refused, latency stays 2
        send(2'd3, 4'b0100, 20'h7, 1, "R9");
        send(2'd1, 4'd0, 20'h0, 0, "R9");
        drain();
        // R4: uniform pattern; R7 address ignored on a bank-0 read
        send(2'd3, 4'b0010, 20'h4, 0, "R4");
        send(2'd1, 4'd0, 20'hABCDE, 0, "R7");
        // R10: exit right behind the read is refused
        send(2'd3, 4'b0010, 20'h0, 1, "R10");
        drain();
        // R10: exit on the cycle the last beat is visible refused, next accepted
        send(2'd1, 4'd0, 20'h0, 0, "R4");
        wait_to(last_issue + 6);
        send(2'd3, 4'b0010, 20'h0, 1, "R10");
        send(2'd3, 4'b0010, 20'h0, 0, "R10");
        send(2'd1, 4'd0, 20'h0, 0, "R10");
        drain();
        // R4: even/odd opposite pattern; R8 back-to-back stream
        send(2'd3, 4'b0010, 20'h5, 0, "R4");
        for (int k = 0; k < 3; k++) begin
            send(2'd1, 4'd0, 20'(k), 0, "R8");
            idle(3);
        end
        drain();
        // R6, R7, R11: illegal commands in training
        send(2'd2, 4'd0, 20'h0, 1, "R6");
        send(2'd1, 4'd3, 20'h0, 1, "R7");
        send(2'd3, 4'b0000, 20'h9, 1, "R11");
        send(2'd3, 4'b0010, 20'h4, 1, "R11");
        send(2'd3, 4'b0001, 20'h0, 1, "R11");
        send(2'd3, 4'b1010, 20'h0, 1, "R9");
        // R11: mode and latency unchanged after the refusals
        send(2'd1, 4'd0, 20'h0, 0, "R11");
        drain();
        // R12: reset during training returns to normal with default latency
        rst_n = 1'b0;
        m_train = 0; m_alt = 0; m_lat = 3;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_valid == 0, "R12", "dq_valid after reset", int'(dq_valid), 0);
        check(err_flag == 0, "R12", "err_flag after reset", int'(err_flag), 0);
        send(2'd1, 4'd0, 20'h0, 0, "R12");
        drain();
        check(q_cyc.size() == 0, "R13", "scoreboard empty", q_cyc.size(), 0);
        summary();
    end

endmodule